// File: doc/BRIEF.md
# Speculative Miss Buffer Allocator

This block hands out request buffers to a core's data-side memory requests ahead of a cache lookup. Each request the core presents is given the lowest-numbered free buffer in the same cycle, without waiting to learn whether the access will need one. In the next cycle the cache lookup reports whether the access hit, and whether it was uncacheable or misaligned. A buffer that turns out to be unneeded goes straight back to the pool. A buffer that is needed stays claimed until the external bus reports completion for its tag.

When every buffer is claimed, the block raises a stall to the core and holds it for as long as the request cannot be served. The same level feeds a performance counter that measures stall duration. A one-cycle pulse at the start of each stall episode feeds a second counter that counts episodes, so their ratio gives the mean stall length.

Each buffer slot is a three-state machine. FREE moves to SPEC on a grant. SPEC lasts exactly one cycle, the lookup cycle. It goes to HELD when the buffer must be kept, or back to FREE on a plain hit. HELD returns to FREE on a completion for its tag, or goes directly to SPEC when it is freed and re-granted in the same cycle. A separate episode machine has two states: RUN, and BLOCKED, which it enters while stall is high. `stall_start` is high when stall is asserted in RUN.

Top module: `spec_buf_alloc`

## Requirements
- R1: An accepted request (`req_valid`=1, `stall`=0) receives the lowest-index buffer available in that cycle, reported on `alloc_tag` as its binary index 0..NBUF-1.
- R2: The lookup qualifiers apply to the request accepted in the previous cycle. A plain hit (`lkp_hit`=1, `lkp_uncached`=0, `lkp_unaligned`=0) returns the buffer to the pool, and it can be granted from the cycle after the lookup.
- R3: A miss (`lkp_hit`=0) keeps the buffer claimed until a completion names its tag.
- R4: An uncacheable access (`lkp_uncached`=1) keeps its buffer even on a hit.
- R5: A misaligned access (`lkp_unaligned`=1) keeps its buffer even on a hit.
- R6: `stall` is high in every cycle in which `req_valid` is high and no buffer is available, and no buffer is granted in such a cycle.
- R7: A completion (`cmp_valid`=1, `cmp_tag`=t) for a held buffer t frees it, and a request in that same cycle may be granted buffer t.
- R8: A completion naming a buffer that is free or awaiting its lookup has no effect.
- R9: `stall_start` is high for exactly the first cycle of each run of consecutive stalled cycles.
- R10: After reset all buffers are free and `stall` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a memory request |
| lkp_hit | input | 1 | Lookup hit for the request accepted last cycle |
| lkp_uncached | input | 1 | That request is uncacheable |
| lkp_unaligned | input | 1 | That request is misaligned |
| cmp_valid | input | 1 | External bus completes a transfer |
| cmp_tag | input | TAG_W | Buffer index of the completed transfer |
| stall | output | 1 | Core must hold its request; also the duration count level |
| alloc_tag | output | TAG_W | Buffer granted to the accepted request |
| stall_start | output | 1 | One-cycle pulse at the start of a stall episode |

## Verification
The assertions assume that the lookup qualifiers always describe the request accepted one cycle earlier. Under that assumption, a slot in SPEC resolves in a single cycle, and a slot's state changes only on a grant, a lookup or a matching completion. Completions are allowed to name any tag, because R8 requires stray tags to be ignored. The stimulus drives the qualifiers in every cycle, and they take effect only when a request was accepted the cycle before. This keeps each stimulus pattern, the long pseudo-random sweep included, inside that protocol by construction.

// File: rtl/sba_pkg.sv
package sba_pkg;
    typedef enum logic [1:0] {
        SLOT_FREE = 2'd0,
        SLOT_SPEC = 2'd1,
        SLOT_HELD = 2'd2
    } slot_state_e;

    typedef enum logic {
        EP_RUN     = 1'b0,
        EP_BLOCKED = 1'b1
    } episode_e;
endpackage

// File: rtl/sba_slot.sv
module sba_slot
    import sba_pkg::*;
#(
    parameter int TAG_W = 2,
    parameter int IDX   = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             grant,
    input  logic             keep,
    input  logic             cmp_valid,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             avail,
    output logic             busy
);
    slot_state_e state_q, state_d;
    logic        cmp_hit;

    assign cmp_hit = cmp_valid && (cmp_tag == TAG_W'(IDX));

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SLOT_FREE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_FREE: if (grant) state_d = SLOT_SPEC;
            SLOT_SPEC: state_d = keep ? SLOT_HELD : SLOT_FREE;
            SLOT_HELD: if (cmp_hit) state_d = grant ? SLOT_SPEC : SLOT_FREE;
            default:   state_d = SLOT_FREE;
        endcase
    end

    always_comb begin
        avail = (state_q == SLOT_FREE) || ((state_q == SLOT_HELD) && cmp_hit);
        busy  = (state_q != SLOT_FREE);
    end

    // R2: lookup phase lasts one cycle; a plain hit goes back to the pool
    assert_hit_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_SPEC && !keep) |=> (state_q == SLOT_FREE));
    // R3: a held buffer stays held until its completion arrives
    assert_held_until_done_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SLOT_HELD && !cmp_hit) |=> (state_q == SLOT_HELD));
    // R1: grants land only on slots that can take them
    assert_grant_to_avail_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> (state_q == SLOT_FREE || state_q == SLOT_HELD));
endmodule

// File: rtl/sba_pick.sv
module sba_pick #(
    parameter int NBUF  = 4,
    parameter int TAG_W = 2
) (
    input  logic [NBUF-1:0]  avail,
    input  logic             req,
    output logic [NBUF-1:0]  grant,
    output logic [TAG_W-1:0] tag,
    output logic             any
);
    always_comb begin
        tag   = '0;
        grant = '0;
        any   = |avail;
        for (int i = NBUF - 1; i >= 0; i--) begin
            if (avail[i]) tag = TAG_W'(i);
        end
        if (req && any) grant[tag] = 1'b1;
    end
endmodule

// File: rtl/spec_buf_alloc.sv
module spec_buf_alloc
    import sba_pkg::*;
#(
    parameter int NBUF  = 4,
    parameter int TAG_W = (NBUF > 1) ? $clog2(NBUF) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             lkp_hit,
    input  logic             lkp_uncached,
    input  logic             lkp_unaligned,
    input  logic             cmp_valid,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             stall,
    output logic [TAG_W-1:0] alloc_tag,
    output logic             stall_start
);
    logic [NBUF-1:0] avail;
    logic [NBUF-1:0] busy;
    logic [NBUF-1:0] grant;
    logic            any_avail;
    logic            keep;
    episode_e        ep_q, ep_d;

    assign keep = !lkp_hit || lkp_uncached || lkp_unaligned;

    generate
        for (genvar g = 0; g < NBUF; g++) begin : g_slot
            sba_slot #(.TAG_W(TAG_W), .IDX(g)) u_slot (
                .clk       (clk),
                .rst_n     (rst_n),
                .grant     (grant[g]),
                .keep      (keep),
                .cmp_valid (cmp_valid),
                .cmp_tag   (cmp_tag),
                .avail     (avail[g]),
                .busy      (busy[g])
            );
        end
    endgenerate

    sba_pick #(.NBUF(NBUF), .TAG_W(TAG_W)) u_pick (
        .avail (avail),
        .req   (req_valid),
        .grant (grant),
        .tag   (alloc_tag),
        .any   (any_avail)
    );

    assign stall = req_valid && !any_avail;

    always_ff @(posedge clk) begin
        if (!rst_n) ep_q <= EP_RUN;
        else        ep_q <= ep_d;
    end

    always_comb begin
        ep_d        = ep_q;
        stall_start = 1'b0;
        unique case (ep_q)
            EP_RUN: begin
                if (stall) begin
                    ep_d        = EP_BLOCKED;
                    stall_start = 1'b1;
                end
            end
            EP_BLOCKED: if (!stall) ep_d = EP_RUN;
            default:    ep_d = EP_RUN;
        endcase
    end

    // R6: a stall means every slot is occupied and nothing is granted
    assert_full_when_stalled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> ($countones(busy) == NBUF) && (grant == '0));
    // R1: at most one buffer granted per cycle
    assert_single_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R9: the episode pulse never lasts two cycles
    assert_start_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_start |=> !stall_start);
    // R9: pulse only while stalled
    assert_start_in_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        stall_start |-> stall);
endmodule

// File: tb/spec_buf_alloc_tb.sv
module spec_buf_alloc_tb;
    localparam int NBUF  = 4;
    localparam int TAG_W = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             lkp_hit = 1'b0;
    logic             lkp_uncached = 1'b0;
    logic             lkp_unaligned = 1'b0;
    logic             cmp_valid = 1'b0;
    logic [TAG_W-1:0] cmp_tag = '0;
    logic             stall;
    logic [TAG_W-1:0] alloc_tag;
    logic             stall_start;

    int n_chk = 0;
    int n_bad = 0;
    int mst [NBUF];   // 0 free, 1 awaiting lookup, 2 held
    bit prev_stall;

    always #4 clk = ~clk;

    spec_buf_alloc #(.NBUF(NBUF), .TAG_W(TAG_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .lkp_hit(lkp_hit),
        .lkp_uncached(lkp_uncached), .lkp_unaligned(lkp_unaligned),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .stall(stall),
        .alloc_tag(alloc_tag), .stall_start(stall_start)
    );

    task automatic chk(input bit ok, input string rq, input string lbl,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s [%s] actual=%0d expected=%0d", rq, lbl, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; req_valid = 0; cmp_valid = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NBUF; i++) mst[i] = 0;
        prev_stall = 0;
    endtask

    task automatic step(input bit r, input bit h, input bit u, input bit a,
                        input bit cv, input int ct, input string lbl);
        bit av [NBUF];
        bit any, exp_stall, exp_start, keep;
        int exp_tag;
        @(negedge clk);
        req_valid = r; lkp_hit = h; lkp_uncached = u; lkp_unaligned = a;
        cmp_valid = cv; cmp_tag = TAG_W'(ct);
        #2;
        any = 0; exp_tag = -1;
        for (int i = 0; i < NBUF; i++) begin
            av[i] = (mst[i] == 0) || (mst[i] == 2 && cv && ct == i);
            if (av[i]) begin
                any = 1;
                if (exp_tag < 0) exp_tag = i;
            end
        end
        exp_stall = r && !any;
        exp_start = exp_stall && !prev_stall;
        chk(stall === exp_stall, "R6", lbl, int'(stall), int'(exp_stall));
        chk(stall_start === exp_start, "R9", lbl, int'(stall_start), int'(exp_start));
        if (r && !exp_stall)
            chk(alloc_tag === TAG_W'(exp_tag), "R1", lbl, int'(alloc_tag), exp_tag);
        keep = !h || u || a;
        for (int i = 0; i < NBUF; i++) begin
            if (r && !exp_stall && i == exp_tag) mst[i] = 1;
            else if (mst[i] == 1) mst[i] = keep ? 2 : 0;
            else if (mst[i] == 2 && cv && ct == i) mst[i] = 0;
        end
        prev_stall = exp_stall;
    endtask

    task automatic run_all();
        logic [15:0] l;
        // R10: reset state
        do_reset();
        #2;
        chk(stall === 1'b0, "R10", "reset", int'(stall), 0);
        step(0, 1, 0, 0, 0, 0, "R10 idle");
        step(1, 1, 0, 0, 0, 0, "R10 first");
        // R2: plain hits recycle buffers 0 and 1
        do_reset();
        for (int k = 0; k < 6; k++) step(1, 1, 0, 0, 0, 0, "R2 hit");
        // R3, R6, R9, R7, R8: fill with misses, stall, free on completion
        do_reset();
        for (int k = 0; k < 4; k++) step(1, 0, 0, 0, 0, 0, "R3 miss");
        step(1, 0, 0, 0, 0, 0, "R6 full");
        step(1, 0, 0, 0, 0, 0, "R9 continue");
        step(1, 0, 0, 0, 1, 2, "R7 reuse");
        step(1, 0, 0, 0, 1, 2, "R8 spec tag");
        step(1, 1, 0, 0, 1, 1, "R7 free");
        step(1, 1, 0, 0, 0, 0, "R3 after");
        // R8: completion to a free tag is ignored
        do_reset();
        step(1, 0, 0, 0, 0, 0, "R8 a");
        step(0, 0, 0, 0, 1, 1, "R8 stray");
        step(1, 1, 0, 0, 1, 3, "R8 b");
        step(1, 1, 0, 0, 0, 0, "R8 c");
        // R4: uncacheable hit keeps its buffer
        do_reset();
        step(1, 1, 0, 0, 0, 0, "R4 a");
        step(1, 1, 1, 0, 0, 0, "R4 b");
        step(1, 1, 0, 0, 0, 0, "R4 c");
        step(1, 1, 0, 0, 0, 0, "R4 d");
        // R5: misaligned hit keeps its buffer
        do_reset();
        step(1, 1, 0, 0, 0, 0, "R5 a");
        step(1, 1, 0, 1, 0, 0, "R5 b");
        step(1, 1, 0, 0, 0, 0, "R5 c");
        step(1, 1, 0, 0, 0, 0, "R5 d");
        // sweep: pseudo-random mix of every input combination
        do_reset();
        l = 16'hACE1;
        for (int k = 0; k < 4000; k++) begin
            l = {l[14:0], l[15] ^ l[13] ^ l[12] ^ l[10]};
            step(l[0] | l[1], l[2] | l[3], l[4] & l[5], l[6] & l[7],
                 l[8] | l[9], int'(l[12:11]), "sweep");
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (150000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule